// File: doc/BRIEF.md
# Weight-Stationary Systolic FIR Array

This block is a four-tap finite impulse response filter arranged as a linear chain of identical multiply-accumulate cells. Each cell keeps one coefficient in place. Samples and running sums move through the chain in the same direction. The sample path has two registers per cell and the sum path has one, so each sample meets every coefficient at the right time. The only logic between any two registers is one multiply and one two-input add. The input sample is never fanned out to more than one cell.

Samples are presented with a valid flag. A sample is accepted on a rising clock edge when its valid flag is high and no coefficient write is requested in the same cycle. Every register in the data path advances only on an accepted sample. Coefficients are written one tap at a time through an indexed port, normally while no samples are flowing. A synchronous reset empties the data path but keeps the coefficients. The result is carried at full precision, and a valid flag travels along the sum path to mark results whose every term comes from a real sample.

Top module: `sfir_array`

## Requirements
- R1: Number accepted samples x(0), x(1), ... from the last reset, and let w_j be the value most recently written to coefficient index j. After sample x(n) is accepted, `y_data` equals the sum over j = 0..TAPS-1 of w_j · x(n-(TAPS-1)-j). With four taps this is the direct-form result delayed by three accepted samples. Samples and coefficients are two's-complement signed.
- R2: `y_vld` is high in the cycle that directly follows the edge accepting a sample, and only when at least 2·TAPS-1 samples (seven by default) have been accepted since reset. In every other cycle it is low. `y_data` changes in the same cycle that `y_vld` rises.
- R3: `y_data` is ACC_W bits wide, with a default of DATA_W+COEF_W+log2(TAPS). It holds the exact sum even when every product is extreme. With all coefficients and all samples at -128, the result is +65536.
- R4: In a cycle where `smp_vld` is low, no sample is taken. `y_data` keeps its value, `y_vld` is low in the following cycle, and later results are the same as if that cycle had not occurred.
- R5: When `coef_we` is high, the coefficient at index `coef_idx` takes the value `coef_din`. Any sample offered in that same cycle is discarded: it does not enter the filter, and `y_vld` is low in the next cycle.
- R6: A synchronous reset (`rst` high) clears `y_data` to zero and drops `y_vld`. It also restarts the fill count of R2. It does not change the stored coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample on `smp_data` is offered this cycle |
| smp_data | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Write one coefficient this cycle |
| coef_idx | input | log2(TAPS) | Tap index of the coefficient write |
| coef_din | input | COEF_W | Signed coefficient value |
| y_vld | output | 1 | `y_data` holds a fresh, fully filled result |
| y_data | output | ACC_W | Signed filter output |

## Verification
A coefficient write and an offered sample can happen in the same cycle. The bench provokes this by raising `coef_we` together with `smp_vld` in the middle of a stream, rewriting a coefficient with its current value so that the data path stays consistent. Two things are judged. The reference model drops that sample and expects `y_vld` low in the next cycle. All later outputs must then match the model's history, which does not contain the dropped sample. Every cycle is compared against a queue-based model, across several patterns: continuous streams, gapped streams, a mid-stream reset and extreme operands.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
   // Smallest accumulator that holds TAPS signed products without overflow.
   function automatic int acc_min(input int data_w, input int coef_w, input int taps);
      return data_w + coef_w + $clog2(taps);
   endfunction
endpackage

// File: rtl/sfir_coef_bank.sv
module sfir_coef_bank #(
   parameter int TAPS   = 4,
   parameter int COEF_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we,
   input  logic [IDX_W-1:0]             idx,
   input  logic [COEF_W-1:0]            din,
   output logic [TAPS-1:0][COEF_W-1:0]  coef_q
);
   logic [TAPS-1:0] stb;

   for (genvar t = 0; t < TAPS; t++) begin : g_coef
      assign stb[t] = we && (idx == IDX_W'(t));
      // Coefficients are configuration, not data: reset leaves them alone.
      always_ff @(posedge clk) begin
         if (stb[t]) coef_q[t] <= din;
      end
   end

   assert_coef_write_R5: assert property (@(posedge clk) disable iff (rst)
      we |=> coef_q[$past(idx)] == $past(din));
   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(stb));
endmodule

// File: rtl/sfir_skew.sv
module sfir_skew #(
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [DATA_W-1:0] d_in,
   input  logic              v_in,
   output logic [DATA_W-1:0] d_out,
   output logic              v_out
);
   logic [DATA_W-1:0] d_q [STAGES];
   logic [STAGES-1:0] v_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q <= '0;
         for (int i = 0; i < STAGES; i++) d_q[i] <= '0;
      end else if (adv) begin
         d_q[0] <= d_in;
         v_q[0] <= v_in;
         for (int i = 1; i < STAGES; i++) begin
            d_q[i] <= d_q[i-1];
            v_q[i] <= v_q[i-1];
         end
      end
   end

   assign d_out = d_q[STAGES-1];
   assign v_out = v_q[STAGES-1];

   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(d_out) && $stable(v_out));
endmodule

// File: rtl/sfir_mac_cell.sv
module sfir_mac_cell #(
   parameter int DATA_W = 8,
   parameter int COEF_W = 8,
   parameter int ACC_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     adv,
   input  logic signed [COEF_W-1:0] coef,
   input  logic signed [DATA_W-1:0] smp,
   input  logic                     smp_vld,
   input  logic signed [ACC_W-1:0]  sum_in,
   input  logic                     sum_vld_in,
   output logic signed [ACC_W-1:0]  sum_out,
   output logic                     sum_vld_out
);
   localparam int PROD_W = DATA_W + COEF_W;

   logic signed [PROD_W-1:0] prod;

   always_comb prod = PROD_W'(coef) * PROD_W'(smp);

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_out     <= '0;
         sum_vld_out <= 1'b0;
      end else if (adv) begin
         sum_out     <= sum_in + ACC_W'(prod);
         sum_vld_out <= sum_vld_in & smp_vld;
      end
   end

   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(sum_out) && $stable(sum_vld_out));
endmodule

// File: rtl/sfir_array.sv
module sfir_array
   import sfir_pkg::*;
#(
   parameter int  TAPS   = 4,
   parameter int  DATA_W = 8,
   parameter int  COEF_W = 8,
   parameter int  ACC_W  = acc_min(DATA_W, COEF_W, TAPS),
   localparam int IDX_W  = $clog2(TAPS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] smp_data,
   input  logic                     coef_we,
   input  logic [IDX_W-1:0]         coef_idx,
   input  logic signed [COEF_W-1:0] coef_din,
   output logic                     y_vld,
   output logic signed [ACC_W-1:0]  y_data
);
   localparam int SKEW = 2;

   if (TAPS < 2 || TAPS > 64) begin : g_bad_taps
      $error("sfir_array: TAPS must lie in 2..64");
   end
   if (ACC_W < acc_min(DATA_W, COEF_W, TAPS)) begin : g_bad_acc
      $error("sfir_array: ACC_W too narrow for a full-precision sum");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("sfir_array: operand widths must be at least 2");
   end

   logic adv, adv_q;
   logic [TAPS-1:0][COEF_W-1:0] coef_q;

   logic signed [DATA_W-1:0] smp_at  [TAPS];
   logic                     sv_at   [TAPS];
   logic signed [ACC_W-1:0]  sum_at  [TAPS+1];
   logic                     sumv_at [TAPS+1];

   // A coefficient write takes the cycle; an offered sample is dropped.
   assign adv = smp_vld & ~coef_we;

   always_ff @(posedge clk) begin
      if (rst) adv_q <= 1'b0;
      else     adv_q <= adv;
   end

   sfir_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_coef (
      .clk(clk), .rst(rst), .we(coef_we), .idx(coef_idx), .din(coef_din),
      .coef_q(coef_q)
   );

   assign smp_at[0]  = smp_data;
   assign sv_at[0]   = 1'b1;
   assign sum_at[0]  = '0;
   assign sumv_at[0] = 1'b1;

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      sfir_mac_cell #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_cell (
         .clk(clk), .rst(rst), .adv(adv),
         .coef(coef_q[k]),
         .smp(smp_at[k]), .smp_vld(sv_at[k]),
         .sum_in(sum_at[k]), .sum_vld_in(sumv_at[k]),
         .sum_out(sum_at[k+1]), .sum_vld_out(sumv_at[k+1])
      );
      if (k < TAPS-1) begin : g_fwd
         sfir_skew #(.DATA_W(DATA_W), .STAGES(SKEW)) u_skew (
            .clk(clk), .rst(rst), .adv(adv),
            .d_in(smp_at[k]), .v_in(sv_at[k]),
            .d_out(smp_at[k+1]), .v_out(sv_at[k+1])
         );
      end
   end

   assign y_data = sum_at[TAPS];
   assign y_vld  = sumv_at[TAPS] & adv_q;

   assert_vld_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
      y_vld |-> $past(smp_vld) && !$past(coef_we));
   assert_write_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      coef_we |=> !y_vld);
   assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !y_vld && y_data == '0);
endmodule

// File: tb/sfir_array_bench.sv
`timescale 1ns/1ps
module sfir_array_bench;
   localparam int TAPS = 4;
   localparam int DW   = 8;
   localparam int CW   = 8;
   localparam int AW   = 18;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                 rst      = 1'b1;
   logic                 smp_vld  = 1'b0;
   logic signed [DW-1:0] smp_data = '0;
   logic                 coef_we  = 1'b0;
   logic [1:0]           coef_idx = '0;
   logic signed [CW-1:0] coef_din = '0;
   logic                 y_vld;
   logic signed [AW-1:0] y_data;

   sfir_array #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .ACC_W(AW)) u_sfir_array (
      .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_din(coef_din),
      .y_vld(y_vld), .y_data(y_data)
   );

   int     errors = 0;
   int     checks = 0;
   int     mw [TAPS];
   int     hist [$];
   longint last_y = 0;
   int     lcg = 12345;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int next_x();
      lcg = lcg * 1103515245 + 12345;
      return ((lcg >>> 16) & 255) - 128;
   endfunction

   // Drive one cycle, then judge the outputs half a period after the edge.
   task automatic step(input bit v, input int x, input bit we, input int idx, input int wd,
                       input string ytag);
      bit     acc;
      bit     exp_v;
      longint exp_y;
      int     n;
      smp_vld  = v;
      smp_data = x[DW-1:0];
      coef_we  = we;
      coef_idx = idx[1:0];
      coef_din = wd[CW-1:0];
      @(negedge clk);
      acc = v && !we;
      if (acc) hist.push_back(x);
      exp_v = acc && (hist.size() >= 2*TAPS-1);
      if (we && v)      chk("R5", "valid after write+sample", longint'(y_vld), 0);
      else if (!acc)    chk("R4", "valid while idle", longint'(y_vld), 0);
      else              chk("R2", "valid after accept", longint'(y_vld), longint'(exp_v));
      if (exp_v) begin
         n = hist.size() - 1;
         exp_y = 0;
         for (int j = 0; j < TAPS; j++) exp_y += longint'(mw[j]) * hist[n-(TAPS-1)-j];
         chk(ytag, "filter output", longint'(y_data), exp_y);
      end
      if (!acc) chk("R4", "output held", longint'(y_data), last_y);
      if (we) mw[idx] = wd;
      last_y = longint'(y_data);
      smp_vld = 1'b0;
      coef_we = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      smp_vld = 1'b0;
      coef_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      hist.delete();
      chk("R6", "valid after reset", longint'(y_vld), 0);
      chk("R6", "output after reset", longint'(y_data), 0);
      last_y = 0;
   endtask

   initial begin
      for (int j = 0; j < TAPS; j++) mw[j] = 0;
      do_reset();
      // Indexed coefficient load (R5), pipeline idle.
      step(0, 0, 1, 0, 3, "R1");
      step(0, 0, 1, 1, -5, "R1");
      step(0, 0, 1, 2, 7, "R1");
      step(0, 0, 1, 3, 2, "R1");
      // Continuous stream (R1, R2).
      for (int i = 0; i < 24; i++) step(1, next_x(), 0, 0, 0, "R1");
      // Gapped stream (R4).
      for (int i = 0; i < 40; i++) step((i % 3) != 1, next_x(), 0, 0, 0, "R4");
      // Write and sample in the same cycle: rewrite tap 2 with its value (R5).
      step(1, 55, 1, 2, 7, "R5");
      for (int i = 0; i < 10; i++) step(1, next_x(), 0, 0, 0, "R5");
      // Mid-stream reset keeps coefficients (R6).
      do_reset();
      for (int i = 0; i < 12; i++) step(1, next_x(), 0, 0, 0, "R6");
      // Extreme operands (R3).
      for (int j = 0; j < TAPS; j++) step(0, 0, 1, j, -128, "R3");
      do_reset();
      for (int i = 0; i < 10; i++) step(1, -128, 0, 0, 0, "R3");
      chk("R3", "extreme sum", longint'(y_data), 65536);
      step(0, 0, 1, 1, 127, "R3");
      step(0, 0, 1, 3, 127, "R3");
      do_reset();
      for (int i = 0; i < 12; i++) step(1, (i % 2) ? 127 : -128, 0, 0, 0, "R3");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule